// File: doc/BRIEF.md
# Descriptor-Table DMA Walker

This block moves data from a storage device into system memory under the control of a table of physical-region descriptors. Software places the table in memory. A start pulse hands the block the table base address, a sector count and a starting logical block address. The block then reads one descriptor at a time over a 32-bit memory-read port. Each descriptor gives a destination buffer address, a byte count and an end-of-table flag. The block splits each descriptor's buffer into chunks of at most one device unit. For each chunk it asks the device data source for the data at the current logical block address, then writes the chunk to memory at the next offset in the buffer.

Two device kinds are supported: a disk with 512-byte sectors and an optical drive with 2048-byte blocks. After each descriptor, the block checks that the bytes moved so far end on a unit boundary. It also checks that the table has not ended before the requested length was delivered. When it finishes, it updates a small set of device and DMA status flags and pulses an interrupt request. Only device-to-memory transfers are carried out. A request in the other direction is refused with an error.

Top module: `prd_dma_walker`

## Requirements
- R1: The descriptor at index i is read as two 32-bit words: the first at table base + 8*i and the second at that address + 4. The index starts at 0 on each accepted start and advances by one after each descriptor is consumed.
- R2: The first word of a descriptor is the buffer base address. In the second word, bits [15:0] are the byte count and bit 31 is end-of-table; bits [30:16] are ignored. A descriptor with a byte count of 0 moves no data.
- R3: `optical`=0 selects a disk with a 512-byte unit, and `optical`=1 selects an optical drive with a 2048-byte unit. Each chunk is the smaller of the unit and the bytes left in the descriptor. Chunks are written at buffer base + 0, then base + (sum of earlier chunk lengths), in order.
- R4: `src_lba` is loaded from `lba_init` on an accepted start. It advances by one each time the device source accepts a chunk request.
- R5: Each of the three requests (memory read, device source, memory write) holds its address and length until acknowledged. At most one request is active at a time. Every chunk is first requested from the source and then written to memory.
- R6: The transfer length is `sect_cnt`*512 bytes, where a `sect_cnt` of 0 means 256 sectors. A descriptor is always consumed to its end, and the remaining length saturates at 0. Once the remaining length is 0, the walk stops after the current descriptor.
- R7: When the length is met on a descriptor that has end-of-table set, the flags become: `dma_active`=0, `dma_err`=0, `dev_busy`=0, `dev_drq`=0, `dev_err`=0, `dev_ready`=1, `dev_seek_ok`=1. `irq` is pulsed for exactly one cycle, in the same cycle the flags change.
- R8: If, after a descriptor, the bytes moved are not a multiple of the unit, the walk aborts. The flags become `dma_err`=1, `dev_err`=1, `dma_active`=0, `dev_busy`=0 and `dev_drq`=0, and `irq` is pulsed. No further descriptor is read.
- R9: If a descriptor carrying end-of-table leaves transfer bytes outstanding, the walk aborts with the same flags and pulse as R8.
- R10: A start with `to_mem`=0 (memory-to-device) is refused. It produces the R8 error flags and an `irq` pulse on the next cycle, with no memory or device request.
- R11: When the length is met on a descriptor without end-of-table, `irq` is pulsed. The flags stay as set at start: `dma_active`=1, `dev_busy`=1, `dev_drq`=1, and the others 0.
- R12: After reset, all flags, `irq` and all requests are 0. An accepted start sets the R11 flag values. A start pulse during a walk is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| to_mem | input | 1 | 1 = device-to-memory, 0 = refused direction |
| optical | input | 1 | 0 = 512-byte disk unit, 1 = 2048-byte optical unit |
| sect_cnt | input | 8 | Sector count, 0 means 256 |
| tbl_base | input | ADDR_W | Descriptor table base address |
| lba_init | input | LBA_W | First logical block address |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Memory read word address |
| rd_ack | input | 1 | Read acknowledge, data valid with it |
| rd_data | input | 32 | Read data word |
| src_req | output | 1 | Chunk request to the device source |
| src_lba | output | LBA_W | Logical block address of the chunk |
| src_len | output | CHK_W | Chunk length in bytes |
| src_ack | input | 1 | Source has the chunk ready |
| wr_req | output | 1 | Memory write request for one chunk |
| wr_addr | output | ADDR_W | Chunk destination address |
| wr_len | output | CHK_W | Chunk length in bytes |
| wr_ack | input | 1 | Chunk write accepted |
| irq | output | 1 | One-cycle interrupt request |
| dma_active | output | 1 | DMA engine active flag |
| dma_err | output | 1 | DMA error flag |
| dev_busy | output | 1 | Device busy flag |
| dev_ready | output | 1 | Device ready flag |
| dev_seek_ok | output | 1 | Seek-complete flag |
| dev_drq | output | 1 | Data-request flag |
| dev_err | output | 1 | Device error flag |

## Verification
The bench sweeps every split point of two-descriptor tables for both device kinds and several handshake latencies. It also targets these corner cases:
- A short trailing chunk of 188 bytes, which must trigger the alignment abort. A design that skipped the check would complete silently.
- A 1000-byte descriptor on the optical drive. A design that checked against the disk unit would miss this misalignment.
- An end-of-table descriptor that falls short of the requested length. Without the check the walker would report success or run past the table.
- A zero-length descriptor, which must be skipped rather than hanging the walker.
- A `sect_cnt` of 0 spread over three descriptors. A design that read this as zero sectors would finish after a single descriptor.
- A descriptor larger than the remaining length. A design with an unsaturated byte count would wrap and keep fetching.
- The refused direction, a non-terminal final descriptor, and a stray start pulse mid-walk. These show whether status is left as specified and whether a second start corrupts the running walk.

// File: rtl/prd_dma_walker.sv
module prd_dma_walker #(
  parameter int ADDR_W    = 32,
  parameter int LBA_W     = 32,
  parameter int IDX_W     = 16,
  parameter int DISK_UNIT = 512,
  parameter int OPT_UNIT  = 2048,
  parameter int CHK_W     = $clog2(OPT_UNIT) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              to_mem,
  input  logic              optical,
  input  logic [7:0]        sect_cnt,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [LBA_W-1:0]  lba_init,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [31:0]       rd_data,
  output logic              src_req,
  output logic [LBA_W-1:0]  src_lba,
  output logic [CHK_W-1:0]  src_len,
  input  logic              src_ack,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [CHK_W-1:0]  wr_len,
  input  logic              wr_ack,
  output logic              irq,
  output logic              dma_active,
  output logic              dma_err,
  output logic              dev_busy,
  output logic              dev_ready,
  output logic              dev_seek_ok,
  output logic              dev_drq,
  output logic              dev_err
);
  localparam int ALG_W   = $clog2(OPT_UNIT);
  localparam int SEC_SH  = $clog2(DISK_UNIT);
  localparam int LEN_W   = SEC_SH + 9;
  localparam int CNT_W   = 16;
  localparam int DESC_SH = 3;

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_SRC, S_WR, S_CHK} st_t;
  st_t st;

  logic              opt_q, eot_q;
  logic [ADDR_W-1:0] tbl_q, dbase;
  logic [IDX_W-1:0]  idx;
  logic [LEN_W-1:0]  rem;
  logic [ALG_W-1:0]  algn;
  logic [LBA_W-1:0]  lba;
  logic [CNT_W-1:0]  dleft, off;
  logic              irq_q, act_q, derr_q, busy_q, rdy_q, seek_q, drq_q, err_q;

  wire [CHK_W-1:0] unit     = opt_q ? CHK_W'(OPT_UNIT) : CHK_W'(DISK_UNIT);
  wire [CHK_W-1:0] chunk    = (dleft > CNT_W'(unit)) ? unit : dleft[CHK_W-1:0];
  wire [LEN_W-1:0] chunk_l  = LEN_W'(chunk);
  wire [8:0]       nsect    = (sect_cnt == 8'd0) ? 9'd256 : {1'b0, sect_cnt};
  wire [LEN_W-1:0] tot_len  = LEN_W'(nsect) << SEC_SH;
  wire [ALG_W-1:0] unit_m1  = unit[ALG_W-1:0] - ALG_W'(1);
  wire             misalign = (algn & unit_m1) != '0;
  wire             last_chk = (dleft == CNT_W'(chunk));

  assign rd_req  = (st == S_RD0) || (st == S_RD1);
  assign rd_addr = tbl_q + (ADDR_W'(idx) << DESC_SH) + ((st == S_RD1) ? ADDR_W'(4) : '0);
  assign src_req = (st == S_SRC);
  assign src_lba = lba;
  assign src_len = chunk;
  assign wr_req  = (st == S_WR);
  assign wr_addr = dbase + ADDR_W'(off);
  assign wr_len  = chunk;

  assign irq         = irq_q;
  assign dma_active  = act_q;
  assign dma_err     = derr_q;
  assign dev_busy    = busy_q;
  assign dev_ready   = rdy_q;
  assign dev_seek_ok = seek_q;
  assign dev_drq     = drq_q;
  assign dev_err     = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      opt_q  <= 1'b0;
      eot_q  <= 1'b0;
      tbl_q  <= '0;
      dbase  <= '0;
      idx    <= '0;
      rem    <= '0;
      algn   <= '0;
      lba    <= '0;
      dleft  <= '0;
      off    <= '0;
      irq_q  <= 1'b0;
      act_q  <= 1'b0;
      derr_q <= 1'b0;
      busy_q <= 1'b0;
      rdy_q  <= 1'b0;
      seek_q <= 1'b0;
      drq_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (!to_mem) begin
            act_q  <= 1'b0;
            derr_q <= 1'b1;
            busy_q <= 1'b0;
            drq_q  <= 1'b0;
            err_q  <= 1'b1;
            irq_q  <= 1'b1;
          end else begin
            opt_q  <= optical;
            tbl_q  <= tbl_base;
            idx    <= '0;
            rem    <= tot_len;
            algn   <= '0;
            lba    <= lba_init;
            act_q  <= 1'b1;
            derr_q <= 1'b0;
            busy_q <= 1'b1;
            rdy_q  <= 1'b0;
            seek_q <= 1'b0;
            drq_q  <= 1'b1;
            err_q  <= 1'b0;
            st     <= S_RD0;
          end
        end
        S_RD0: if (rd_ack) begin
          dbase <= ADDR_W'(rd_data);
          st    <= S_RD1;
        end
        S_RD1: if (rd_ack) begin
          dleft <= rd_data[CNT_W-1:0];
          eot_q <= rd_data[31];
          off   <= '0;
          st    <= (rd_data[CNT_W-1:0] == '0) ? S_CHK : S_SRC;
        end
        S_SRC: if (src_ack) begin
          lba <= lba + LBA_W'(1);
          st  <= S_WR;
        end
        S_WR: if (wr_ack) begin
          off   <= off + CNT_W'(chunk);
          dleft <= dleft - CNT_W'(chunk);
          algn  <= algn + ALG_W'(chunk);
          rem   <= (rem > chunk_l) ? rem - chunk_l : '0;
          st    <= last_chk ? S_CHK : S_SRC;
        end
        S_CHK: begin
          idx <= idx + IDX_W'(1);
          if (misalign || (eot_q && rem != '0)) begin
            act_q  <= 1'b0;
            derr_q <= 1'b1;
            busy_q <= 1'b0;
            drq_q  <= 1'b0;
            err_q  <= 1'b1;
            irq_q  <= 1'b1;
            st     <= S_IDLE;
          end else if (rem == '0) begin
            irq_q <= 1'b1;
            st    <= S_IDLE;
            if (eot_q) begin
              act_q  <= 1'b0;
              derr_q <= 1'b0;
              busy_q <= 1'b0;
              rdy_q  <= 1'b1;
              seek_q <= 1'b1;
              drq_q  <= 1'b0;
              err_q  <= 1'b0;
            end
          end else begin
            st <= S_RD0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prd_walker_checks.sv
module prd_walker_checks #(
  parameter int ADDR_W    = 32,
  parameter int LBA_W     = 32,
  parameter int CHK_W     = 12,
  parameter int DISK_UNIT = 512,
  parameter int OPT_UNIT  = 2048
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic              rd_ack,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              src_req,
  input logic              src_ack,
  input logic [LBA_W-1:0]  src_lba,
  input logic              wr_req,
  input logic              wr_ack,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CHK_W-1:0]  wr_len,
  input logic              opt_q,
  input logic              irq,
  input logic              dma_active,
  input logic              dma_err,
  input logic              dev_busy,
  input logic              dev_ready,
  input logic              dev_seek_ok,
  input logic              dev_drq,
  input logic              dev_err
);
  assert_one_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req, src_req, wr_req}));

  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

  assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_len));

  assert_src_then_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    src_req && src_ack |=> wr_req);

  assert_chunk_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wr_len != '0) && (wr_len <= (opt_q ? CHK_W'(OPT_UNIT) : CHK_W'(DISK_UNIT))));

  assert_lba_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    src_req && src_ack |=> src_lba == $past(src_lba) + LBA_W'(1));

  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_done_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !dma_err && !dma_active |-> dev_ready && dev_seek_ok && !dev_busy && !dev_drq && !dev_err);

  assert_err_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq && dma_err |-> dev_err && !dma_active && !dev_busy && !dev_drq);

  assert_no_req_after_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq && dma_err |-> !rd_req && !src_req && !wr_req);
endmodule

bind prd_dma_walker prd_walker_checks #(
  .ADDR_W(ADDR_W), .LBA_W(LBA_W), .CHK_W(CHK_W), .DISK_UNIT(DISK_UNIT), .OPT_UNIT(OPT_UNIT)
) u_checks (
  .clk(clk), .rst_n(rst_n),
  .rd_req(rd_req), .rd_ack(rd_ack), .rd_addr(rd_addr),
  .src_req(src_req), .src_ack(src_ack), .src_lba(src_lba),
  .wr_req(wr_req), .wr_ack(wr_ack), .wr_addr(wr_addr), .wr_len(wr_len),
  .opt_q(opt_q), .irq(irq), .dma_active(dma_active), .dma_err(dma_err),
  .dev_busy(dev_busy), .dev_ready(dev_ready), .dev_seek_ok(dev_seek_ok),
  .dev_drq(dev_drq), .dev_err(dev_err)
);

// File: tb/tb_prd_dma_walker.sv
module tb_prd_dma_walker;
  localparam logic [31:0] TBASE = 32'h0000_2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, to_mem = 1'b1, optical = 1'b0;
  logic [7:0]  sect_cnt = 8'd0;
  logic [31:0] tbl_base = TBASE, lba_init = 32'd0;
  logic        rd_req, src_req, wr_req;
  logic        rd_ack = 1'b0, src_ack = 1'b0, wr_ack = 1'b0;
  logic [31:0] rd_addr, rd_data, src_lba, wr_addr;
  logic [11:0] src_len, wr_len;
  logic        irq, dma_active, dma_err, dev_busy, dev_ready, dev_seek_ok, dev_drq, dev_err;

  always #2 clk = ~clk;

  prd_dma_walker dut (
    .clk(clk), .rst_n(rst_n), .start(start), .to_mem(to_mem), .optical(optical),
    .sect_cnt(sect_cnt), .tbl_base(tbl_base), .lba_init(lba_init),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .src_req(src_req), .src_lba(src_lba), .src_len(src_len), .src_ack(src_ack),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_len(wr_len), .wr_ack(wr_ack),
    .irq(irq), .dma_active(dma_active), .dma_err(dma_err), .dev_busy(dev_busy),
    .dev_ready(dev_ready), .dev_seek_ok(dev_seek_ok), .dev_drq(dev_drq), .dev_err(dev_err)
  );

  int          nchecks = 0, nfail = 0;
  bit          finished = 0;
  logic [31:0] d_base [16];
  int          d_cnt  [16];
  bit          d_eot  [16];
  int          lat = 0, wcnt = 0;
  logic [31:0] log_ra [512], log_wa [512], log_lba [512];
  int          log_wl [512];
  int          nrd = 0, nsrc = 0, nwr = 0;
  logic [31:0] exp_wa [512], exp_lba [512];
  int          exp_wl [512];
  int          exp_nw, exp_nrd, exp_out;
  logic [31:0] lba0;

  function automatic logic [31:0] mem_word(logic [31:0] a);
    logic [31:0] o = a - TBASE;
    int i;
    if (o >= 32'd128) return 32'd0;
    i = int'(o >> 3);
    if (o[2]) return {d_eot[i], 15'h2A55, d_cnt[i][15:0]};
    return d_base[i];
  endfunction
  assign rd_data = mem_word(rd_addr);

  always @(negedge clk) begin
    if (!rst_n) begin
      rd_ack = 0; src_ack = 0; wr_ack = 0; wcnt = 0;
    end else if (rd_req || src_req || wr_req) begin
      if (wcnt >= lat) begin
        rd_ack = rd_req; src_ack = src_req; wr_ack = wr_req; wcnt = 0;
        if (rd_req && nrd < 512) begin log_ra[nrd] = rd_addr; nrd++; end
        if (src_req && nsrc < 512) begin log_lba[nsrc] = src_lba; nsrc++; end
        if (wr_req && nwr < 512) begin log_wa[nwr] = wr_addr; log_wl[nwr] = int'(wr_len); nwr++; end
      end else begin
        rd_ack = 0; src_ack = 0; wr_ack = 0; wcnt++;
      end
    end else begin
      rd_ack = 0; src_ack = 0; wr_ack = 0; wcnt = 0;
    end
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic clear_desc();
    for (int i = 0; i < 16; i++) begin
      d_base[i] = 32'h0010_0000 + 32'h0002_0000 * i;
      d_cnt[i]  = 0;
      d_eot[i]  = 1'b1;
    end
  endtask

  task automatic set_desc(input int i, input int cnt, input bit eot);
    d_cnt[i] = cnt;
    d_eot[i] = eot;
  endtask

  task automatic model(input bit opt, input bit dir, input int sc);
    int     unit = opt ? 2048 : 512;
    longint rem = longint'((sc == 0) ? 256 : sc) * 512;
    int     algn = 0, idx = 0;
    exp_nw = 0;
    if (!dir) begin exp_out = 1; exp_nrd = 0; return; end
    forever begin
      int left = d_cnt[idx];
      int off = 0;
      while (left > 0) begin
        int c = (left > unit) ? unit : left;
        exp_wa[exp_nw]  = d_base[idx] + off;
        exp_wl[exp_nw]  = c;
        exp_lba[exp_nw] = lba0 + exp_nw;
        exp_nw++;
        off += c; left -= c; algn += c;
        rem = (rem > c) ? rem - c : 0;
      end
      idx++;
      if ((algn % unit) != 0 || (d_eot[idx-1] && rem > 0)) begin exp_out = 1; break; end
      if (rem == 0) begin exp_out = d_eot[idx-1] ? 0 : 2; break; end
      if (idx >= 16) begin exp_out = 1; break; end
    end
    exp_nrd = 2 * idx;
  endtask

  task automatic run(input bit opt, input bit dir, input int sc, input int latency,
                     input bit poke, input string rq);
    int cyc = 0;
    logic [6:0] st, es;
    nrd = 0; nsrc = 0; nwr = 0;
    lba0 = 32'h1000_0000 + 32'(sc * 97 + latency);
    model(opt, dir, sc);
    lat = latency;
    @(negedge clk);
    optical = opt; to_mem = dir; sect_cnt = 8'(sc); lba_init = lba0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!irq && cyc < 30000) begin
      if (poke && cyc == 3) begin start = 1'b1; to_mem = 1'b0; optical = !opt; end
      if (poke && cyc == 4) begin start = 1'b0; to_mem = dir; optical = opt; end
      @(negedge clk);
      cyc++;
    end
    chk(cyc < 30000, {rq, " irq seen"}, cyc, 0);
    st = {dma_active, dma_err, dev_busy, dev_ready, dev_seek_ok, dev_drq, dev_err};
    es = (exp_out == 0) ? 7'b0001100 : (exp_out == 1) ? 7'b0100001 : 7'b1010010;
    chk(st == es, {rq, " status flags"}, st, es);
    @(negedge clk);
    chk(irq == 1'b0, "R7 irq one cycle", irq, 0);
    chk(nwr == exp_nw, {rq, " R3 chunk count"}, nwr, exp_nw);
    chk(nsrc == exp_nw, {rq, " R5 source count"}, nsrc, exp_nw);
    chk(nrd == exp_nrd, {rq, " R1 read count"}, nrd, exp_nrd);
    for (int i = 0; i < nwr && i < exp_nw; i++) begin
      chk(log_wa[i] == exp_wa[i], "R3 chunk address", log_wa[i], exp_wa[i]);
      chk(log_wl[i] == exp_wl[i], "R3 chunk length", log_wl[i], exp_wl[i]);
    end
    for (int i = 0; i < nsrc && i < exp_nw; i++)
      chk(log_lba[i] == exp_lba[i], "R4 lba", log_lba[i], exp_lba[i]);
    for (int i = 0; i < nrd; i++)
      chk(log_ra[i] == TBASE + 32'(8 * (i / 2) + 4 * (i % 2)), "R1 descriptor address",
          log_ra[i], TBASE + 32'(8 * (i / 2) + 4 * (i % 2)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchecks++; nfail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    clear_desc();
    repeat (3) @(negedge clk);
    chk({irq, dma_active, dma_err, dev_busy, dev_ready, dev_seek_ok, dev_drq, dev_err,
         rd_req, src_req, wr_req} == '0, "R12 reset state", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);

    clear_desc(); set_desc(0, 2048, 1);
    run(0, 1, 4, 0, 0, "R7");
    clear_desc(); set_desc(0, 1024, 0); set_desc(1, 512, 1);
    run(0, 1, 3, 1, 0, "R7");
    clear_desc(); set_desc(0, 4096, 1);
    run(1, 1, 8, 2, 0, "R7");
    clear_desc(); set_desc(0, 1000, 0); set_desc(1, 7192, 1);
    run(1, 1, 4, 0, 0, "R8");
    clear_desc(); set_desc(0, 700, 1);
    run(0, 1, 2, 1, 0, "R8");
    clear_desc(); set_desc(0, 1024, 1);
    run(0, 1, 4, 0, 0, "R9");
    clear_desc(); set_desc(0, 512, 1);
    run(0, 0, 1, 0, 0, "R10");
    clear_desc(); set_desc(0, 512, 0); set_desc(1, 512, 1);
    run(0, 1, 1, 1, 0, "R11");
    clear_desc(); set_desc(0, 65024, 0); set_desc(1, 65024, 0); set_desc(2, 1024, 1);
    run(0, 1, 0, 0, 0, "R6");
    clear_desc(); set_desc(0, 1536, 1);
    run(0, 1, 2, 2, 0, "R6");
    clear_desc(); set_desc(0, 0, 0); set_desc(1, 512, 1);
    run(0, 1, 1, 0, 0, "R2");
    clear_desc(); set_desc(0, 1536, 1);
    run(0, 1, 3, 1, 1, "R12");

    for (int opt = 0; opt < 2; opt++)
      for (int n = 2; n <= 5; n++)
        for (int s = 1; s < n; s++) begin
          int u = opt ? 2048 : 512;
          clear_desc(); set_desc(0, s * u, 0); set_desc(1, (n - s) * u, 1);
          run(opt[0], 1, opt ? 4 * n : n, (n + s) % 3, 0, "R6");
        end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule